// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A start request launches a conversion. The block clears its approximation register and pulls its active-low busy flag down. It then presents a trial code to an external DAC and resolves one bit per converter clock, from the most significant bit to the least, using a single comparator decision each time. When the last bit is settled, the finished word goes into a separate result latch and busy returns high.

The converter clock is the block clock, and all decisions are taken on its rising edge. One settle cycle separates the accepted start from the first decision, so a conversion occupies `WIDTH + 1` cycles. After a conversion ends, a programmable reacquisition window gives the analog sample stage time to settle, and starts that arrive inside that window are dropped. The result latch is a plain register that can be read in any cycle. It keeps the previous word until the new one is loaded. Control pins (start, busy) are plain levels with no handshake. No data stream enters the block, so no valid/ready interface applies.

Top module: `sar_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: `busy_n` = 1, `trial` = 0, `result` = 0, and the reacquisition window is cleared, so a start in the first cycle after reset is accepted.
- R2: A `start` sampled high at a rising edge while idle and outside the reacquisition window is accepted. After that edge, `busy_n` = 0 and `trial` = 12'h800 (the register is cleared and only the MSB trial bit is set).
- R3: `busy_n` stays low for exactly `WIDTH + 1` = 13 consecutive cycles per conversion, then returns high.
- R4: The first rising edge after acceptance is a settle edge with no decision. The next 12 edges decide bits 11, 10, … 0 in that order, one bit per edge. After deciding bit i>0, `trial` holds the decided upper bits, a 1 at bit i-1 and zeros below it.
- R5: At the edge that decides bit i, the bit is kept at 1 when `cmp` = 1 (input at or above the trial level) and cleared when `cmp` = 0.
- R6: A `start` that arrives while `busy_n` = 0 is ignored. The conversion length and its result are unchanged.
- R7: `result` changes only on the edge where `busy_n` returns high, and at that edge it takes the complete 12-bit word. Throughout a conversion it shows the previous word.
- R8: A start on any of the `GAP_CYCLES` rising edges after the edge that ends a conversion is ignored. With `start` held high, the next conversion is accepted on edge `GAP_CYCLES + 1`.
- R9: The result is natural binary. With an ideal comparator (`cmp` = input ≥ `trial`), input 0 gives 12'h000, full scale gives 12'hFFF, and any input code v gives v.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled on each rising edge |
| cmp | input | 1 | Comparator decision: 1 when the analog input is at or above the DAC level |
| trial | output | 12 | Trial code driven to the DAC |
| busy_n | output | 1 | Low while a conversion is in progress |
| result | output | 12 | Latched word of the most recently completed conversion |

## Verification
Two functions can collide in one cycle. The first pair is the final bit decision with its latch load, against a start that arrives on that very edge or just after it. The second pair is the end of the reacquisition window against a start held high across it. The bench holds `start` high from the cycle busy rises and counts the edges until the next acceptance. It also pulses `start` in the middle of a conversion. A behavioural model advances on every clock and predicts `busy_n`, `trial` and `result`, which are compared each cycle. Separate directed checks measure the busy length, confirm that the latch holds the old word, and check the extreme codes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_RESOLVE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int GAP_CYCLES = 4,
  localparam int IW = $clog2(WIDTH),
  localparam int GW = $clog2(GAP_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          decide,
  output logic          last,
  output logic [IW-1:0] idx,
  output logic          busy_n
);
  seq_state_e    state;
  logic [GW-1:0] gap;
  logic          gap_clear;

  assign gap_clear = (gap == '0);
  assign load      = (state == ST_IDLE) && start && gap_clear;
  assign decide    = (state == ST_RESOLVE);
  assign last      = decide && (idx == '0);
  assign busy_n    = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      gap   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load)            state <= ST_SETTLE;
          else if (!gap_clear) gap   <= gap - 1'b1;
        end
        ST_SETTLE: begin
          state <= ST_RESOLVE;
          idx   <= IW'(WIDTH - 1);
        end
        ST_RESOLVE: begin
          if (idx == '0) begin
            state <= ST_IDLE;
            gap   <= GW'(GAP_CYCLES);
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: settle edge is always followed by the MSB decision
  p_settle_msb_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |=> (state == ST_RESOLVE && idx == IW'(WIDTH - 1)));

  // R4: bit index walks down by one per edge
  p_idx_down_r4: assert property (@(posedge clk) disable iff (rst)
    (decide && idx != '0) |=> (decide && idx == $past(idx) - 1'b1));

  // R6: a running conversion is not abandoned before its last decision
  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_n && !last) |=> !busy_n);

  // R8: no acceptance while the reacquisition window runs
  p_gap_block_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_n && !gap_clear) |=> busy_n);
endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg #(
  parameter int WIDTH = 12,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             decide,
  input  logic             last,
  input  logic [IW-1:0]    idx,
  input  logic             cmp,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] sar_q;
  logic [WIDTH-1:0] sar_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      always_comb begin
        if (load)                           sar_d[i] = 1'b1;
        else if (decide && idx == IW'(i))   sar_d[i] = cmp;
        else                                sar_d[i] = sar_q[i];
      end
    end else begin : g_low
      always_comb begin
        if (load)                             sar_d[i] = 1'b0;
        else if (decide && idx == IW'(i))     sar_d[i] = cmp;
        else if (decide && idx == IW'(i + 1)) sar_d[i] = 1'b1;
        else                                  sar_d[i] = sar_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q  <= '0;
      result <= '0;
    end else begin
      sar_q <= sar_d;
      if (last) result <= sar_d;
    end
  end

  assign trial = sar_q;

  // R5: decided bit equals the comparator verdict of that edge
  p_keep_bit_r5: assert property (@(posedge clk) disable iff (rst)
    decide |=> (sar_q[$past(idx)] == $past(cmp)));

  // R7: latch only moves on the final decision
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(result));
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH      = 12,
  parameter int GAP_CYCLES = 4,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp,
  output logic [WIDTH-1:0] trial,
  output logic             busy_n,
  output logic [WIDTH-1:0] result
);
  logic          load;
  logic          decide;
  logic          last;
  logic [IW-1:0] idx;

  sar_seq_ctrl #(.WIDTH(WIDTH), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .decide(decide),
    .last(last), .idx(idx), .busy_n(busy_n)
  );

  sar_seq_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst(rst), .load(load), .decide(decide), .last(last),
    .idx(idx), .cmp(cmp), .trial(trial), .result(result)
  );

  // R2: an accepted start clears the register to the MSB trial and drops busy
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (!busy_n && trial == {1'b1, {(WIDTH-1){1'b0}}}));

  // R3: the LSB decision ends the conversion on the same edge
  p_end_r3: assert property (@(posedge clk) disable iff (rst)
    last |=> busy_n);
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int W   = 12;
  localparam int GAP = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp;
  logic [W-1:0] trial;
  logic         busy_n;
  logic [W-1:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp = (vin >= trial);

  sar_seq #(.WIDTH(W), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmp(cmp),
    .trial(trial), .busy_n(busy_n), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_busy = 0, m_step = 0, m_sar = 0, m_res = 0, m_gap = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_sar = 0; m_res = 0; m_gap = 0;
    end else if (!m_busy) begin
      if (start && m_gap == 0) begin
        m_busy = 1; m_step = 0; m_sar = 1 << (W - 1);
      end else if (m_gap > 0) m_gap--;
    end else if (m_step == 0) begin
      m_step = 1;
    end else begin
      int b;
      b = W - m_step;
      if (!(int'(vin) >= m_sar)) m_sar = m_sar & ~(1 << b);
      if (b > 0) m_sar = m_sar | (1 << (b - 1));
      else begin m_res = m_sar; m_busy = 0; m_gap = GAP; end
      m_step++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy_n == !m_busy, "R3 busy per-cycle", busy_n, !m_busy);
      chk(trial == m_sar[W-1:0], "R4 trial per-cycle", trial, m_sar);
      chk(result == m_res[W-1:0], "R7 result per-cycle", result, m_res);
    end
  end

  task automatic convert(input logic [W-1:0] v, input bit poke);
    logic [W-1:0] old;
    int n;
    vin = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy_n == 1'b0, "R2 busy after start", busy_n, 0);
    chk(trial == 12'h800, "R2 MSB trial", trial, 12'h800);
    old = result;
    n = 1;
    while (!busy_n) begin
      @(negedge clk);
      start = (poke && n == 5);
      if (!busy_n) begin
        n++;
        chk(result == old, "R7 old word held", result, old);
      end
    end
    start = 1'b0;
    chk(n == W + 1, poke ? "R6 busy length with mid start" : "R3 busy length", n, W + 1);
    chk(result == v, "R5 R9 result word", result, v);
    repeat (GAP + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy_n == 1'b1, "R1 busy idle", busy_n, 1);
    chk(trial == '0, "R1 trial cleared", trial, 0);
    chk(result == '0, "R1 result cleared", result, 0);

    convert(12'hA5C, 1'b0);
    convert(12'h000, 1'b0);    // R9 zero input
    convert(12'hFFF, 1'b1);    // R9 full scale, R6 mid-conversion start
    convert(12'h7FF, 1'b1);
    convert(12'h800, 1'b0);
    convert(12'h001, 1'b0);

    // R8: start held high straight from the end of a conversion
    vin = 12'h3C3;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!busy_n) @(negedge clk);
    start = 1'b1;
    begin
      int k;
      k = 1;
      while (1) begin
        @(negedge clk);
        if (busy_n) k++;
        else break;
        if (k > 50) break;
      end
      chk(k == GAP + 1, "R8 edges until reacceptance", k, GAP + 1);
    end
    start = 1'b0;
    while (!busy_n) @(negedge clk);
    chk(result == 12'h3C3, "R8 R9 word after gap test", result, 12'h3C3);
    repeat (GAP + 2) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule